// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Controller

This block is the interrupt-message engine of a PCIe endpoint. It keeps a table of per-vector message entries (a 64-bit target address, a 32-bit payload and a per-vector mask bit) and a packed array of pending bits. Device logic raises interrupts by naming a vector. The block either turns the request into an outgoing address/data message or, when the vector is masked, records it as pending. A pending request is replayed as soon as the vector becomes unmasked.

Software reaches the table and the pending array through a 32-bit word-addressed register port. The capability's enable and mask-all bits arrive on a separate control write. Device logic declares the vectors it will actually drive through use and unuse events. A vector with a zero use count never delivers and never latches. Messages leave on a valid/ready handshake. When several are waiting, the lowest vector number goes first.

Top module: `msix_unit`

## Requirements
- R1: The `tbl_size` output always equals NUM_VEC minus one.
- R2: Table word address 4*v+k selects word k of vector v's entry: k=0 address low, k=1 address high, k=2 payload, k=3 control. In the control word only bit 0 (the vector mask) is stored, and the other bits read zero. Words for vectors at or beyond NUM_VEC read zero, and writes to them change nothing.
- R3: After reset every table word is zero except the control words, which read 1. All pending bits are clear, enable and mask-all are clear, and all use counts are zero.
- R4: A vector is effectively masked when enable is 0, when mask-all is 1, or when its own mask bit is 1. A request sampled at edge E on an unmasked vector with a nonzero use count makes `msg_valid` rise after edge E+1, carrying that entry's {high,low} address and payload.
- R5: A request on an effectively masked vector with a nonzero use count sets that vector's pending bit at the sampling edge and produces no message.
- R6: Pending bit v sits in pending word v/32 at bit v mod 32, which is byte v/8 bit v mod 8 in little-endian order. The array spans NUM_VEC rounded up to a multiple of 64 bits. Words beyond NUM_VEC read zero, and writes to the pending space change nothing.
- R7: When a vector goes from masked to unmasked with its pending bit set, the bit is cleared after the next edge and the message is valid one edge later. This applies whether the change comes from a table write or from a control write.
- R8: A request is ignored when its vector number is NUM_VEC or above, or when that vector's use count is zero.
- R9: A use event increments the selected vector's count and an unuse event decrements it. An unuse that brings the count to zero clears the pending bit. An unuse on a zero count has no effect.
- R10: A control write that leaves enable at 1 drives `intx_deassert` high for exactly the following cycle. A control write that leaves enable at 0 does not.
- R11: While `msg_valid` is high and `msg_ready` is low, the address and payload hold steady. Messages that are waiting leave in ascending vector order, one per accepted handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_space | input | 1 | 0 selects the vector table, 1 selects the pending array |
| reg_addr | input | REG_AW | 32-bit word address within the selected space |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current address (combinational) |
| ctl_wen | input | 1 | Control-byte write strobe |
| ctl_enable | input | 1 | New value of the enable bit |
| ctl_maskall | input | 1 | New value of the mask-all bit |
| intx_deassert | output | 1 | One-cycle request to drop the legacy wire interrupt |
| tbl_size | output | 11 | Vector count minus one |
| req_valid | input | 1 | Interrupt request strobe |
| req_vec | input | REQ_W | Requested vector number |
| use_en | input | 1 | Increment the use count of `cnt_vec` |
| unuse_en | input | 1 | Decrement the use count of `cnt_vec` |
| cnt_vec | input | REQ_W | Vector addressed by the use/unuse event |
| msg_valid | output | 1 | Outgoing message available |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message payload |

## Verification
State changes are due at the edge that samples the stimulus. Table contents, pending bits, use counts and the `intx_deassert` pulse are therefore read one nanosecond after that edge. A message for an unmasked request is due one edge later. A replay caused by unmasking needs one edge to notice the mask change and a second to present the message. The bench steps the clock one edge at a time through every such sequence and asserts the idle state on the intermediate cycle, so both an early and a late output count as a failure. Eight vectors are swept in full: each has its own programmed entry, each is parked, replayed and delivered directly, and burst replays are checked cycle by cycle for ascending order.

// File: rtl/msix_pkg.sv
// Shared definitions for the interrupt-message vector controller.
// Assumes: entries are four 32-bit words; vector numbers fit vec_width().
package msix_pkg;

    // Word slots inside one table entry, in address order.
    typedef enum logic [1:0] {
        SLOT_ADDR_LO = 2'd0,
        SLOT_ADDR_HI = 2'd1,
        SLOT_DATA    = 2'd2,
        SLOT_CTRL    = 2'd3
    } entry_slot_e;

    // Bits needed to number n vectors (at least one).
    function automatic int vec_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/msix_vec_table.sv
// Vector table: per-vector address, payload and mask bit in flip-flops.
// Provides a word-addressed write/read port and exposes every entry in
// parallel to the delivery logic. Assumes REG_AW >= vec_width(NUM_VEC)+2.
module msix_vec_table
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int REG_AW  = 13,
    localparam int VEC_W  = vec_width(NUM_VEC),
    localparam int TV_W   = REG_AW - 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [REG_AW-1:0]       addr,
    input  logic [31:0]             wdata,
    output logic [31:0]             rdata,
    output logic [NUM_VEC-1:0]      vmask,
    output logic [NUM_VEC*64-1:0]   ent_addr,
    output logic [NUM_VEC*32-1:0]   ent_data
);

    logic [TV_W-1:0]    tv;
    entry_slot_e        slot;
    logic               in_range;
    logic [31:0]        lo_q  [NUM_VEC];
    logic [31:0]        hi_q  [NUM_VEC];
    logic [31:0]        dat_q [NUM_VEC];
    logic [NUM_VEC-1:0] msk_q;

    assign tv       = addr[REG_AW-1:2];
    assign slot     = entry_slot_e'(addr[1:0]);
    assign in_range = (32'(tv) < NUM_VEC);
    assign vmask    = msk_q;

    for (genvar g = 0; g < NUM_VEC; g++) begin : g_entry
        logic wr_hit;
        assign wr_hit = wr_en && (tv == TV_W'(g));

        // Entry storage: reset to zero with the mask bit set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q[g]  <= '0;
                hi_q[g]  <= '0;
                dat_q[g] <= '0;
                msk_q[g] <= 1'b1;
            end else if (wr_hit) begin
                case (slot)
                    SLOT_ADDR_LO: lo_q[g]  <= wdata;
                    SLOT_ADDR_HI: hi_q[g]  <= wdata;
                    SLOT_DATA:    dat_q[g] <= wdata;
                    SLOT_CTRL:    msk_q[g] <= wdata[0];
                endcase
            end
        end

        assign ent_addr[g*64 +: 64] = {hi_q[g], lo_q[g]};
        assign ent_data[g*32 +: 32] = dat_q[g];
    end

    // Read mux: zero outside the implemented vectors.
    always_comb begin
        rdata = '0;
        if (in_range) begin
            case (slot)
                SLOT_ADDR_LO: rdata = lo_q[tv[VEC_W-1:0]];
                SLOT_ADDR_HI: rdata = hi_q[tv[VEC_W-1:0]];
                SLOT_DATA:    rdata = dat_q[tv[VEC_W-1:0]];
                SLOT_CTRL:    rdata = {31'd0, msk_q[tv[VEC_W-1:0]]};
            endcase
        end
    end

endmodule

// File: rtl/msix_pend_ctl.sv
// Per-vector pending, use-count and send-queue state.
// A request on a live vector either queues a send (unmasked) or parks a
// pending bit (masked). A masked-to-unmasked edge, seen one cycle late
// through the registered previous mask, turns a parked bit into a send.
// Assumes grant is one-hot or zero and only names queued vectors.
module msix_pend_ctl #(
    parameter int NUM_VEC = 8,
    parameter int REQ_W   = 4,
    parameter int CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [REQ_W-1:0]   req_vec,
    input  logic               use_en,
    input  logic               unuse_en,
    input  logic [REQ_W-1:0]   cnt_vec,
    input  logic [NUM_VEC-1:0] eff_mask,
    input  logic [NUM_VEC-1:0] grant,
    output logic [NUM_VEC-1:0] pend_q,
    output logic [NUM_VEC-1:0] send_q
);

    logic [NUM_VEC-1:0] prev_mask_q;

    // Remember last cycle's effective mask to detect unmask edges.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_mask_q <= '1;
        else        prev_mask_q <= eff_mask;
    end

    for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
        logic [CNT_W-1:0] cnt_q;
        logic hit, live, use_hit, unuse_hit, drop, unmasking, replay, fire, park;

        // Decode this vector's events for the current cycle.
        always_comb begin
            hit       = req_valid && (req_vec == REQ_W'(g));
            live      = (cnt_q != '0);
            use_hit   = use_en && !unuse_en && (cnt_vec == REQ_W'(g));
            unuse_hit = unuse_en && !use_en && (cnt_vec == REQ_W'(g));
            drop      = unuse_hit && (cnt_q == CNT_W'(1));
            unmasking = prev_mask_q[g] && !eff_mask[g];
            replay    = unmasking && pend_q[g] && !drop;
            fire      = hit && live && !eff_mask[g];
            park      = hit && live && eff_mask[g];
        end

        // Use count: saturating increment, decrement stops at zero.
        always_ff @(posedge clk) begin
            if (!rst_n)                          cnt_q <= '0;
            else if (use_hit && cnt_q != '1)     cnt_q <= cnt_q + CNT_W'(1);
            else if (unuse_hit && cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
        end

        // Pending bit and send-queue bit for this vector.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q[g] <= 1'b0;
                send_q[g] <= 1'b0;
            end else begin
                pend_q[g] <= (drop || replay) ? 1'b0 : (pend_q[g] || park);
                send_q[g] <= (send_q[g] && !grant[g]) || fire || replay;
            end
        end
    end

endmodule

// File: rtl/msix_msg_out.sv
// Output stage: picks the lowest queued vector and registers its address
// and payload onto a valid/ready handshake. Holds the message while stalled.
// Assumes the entry buses are stable while a vector waits in the queue.
module msix_msg_out
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    localparam int VEC_W  = vec_width(NUM_VEC)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_VEC-1:0]    send,
    input  logic [NUM_VEC*64-1:0] ent_addr,
    input  logic [NUM_VEC*32-1:0] ent_data,
    input  logic                  msg_ready,
    output logic [NUM_VEC-1:0]    grant,
    output logic                  msg_valid,
    output logic [63:0]           msg_addr,
    output logic [31:0]           msg_data
);

    logic [VEC_W-1:0] sel;
    logic             any, load;

    // Lowest-numbered queued vector wins.
    always_comb begin
        sel = '0;
        for (int i = NUM_VEC - 1; i >= 0; i--) begin
            if (send[i]) sel = VEC_W'(i);
        end
        any   = |send;
        load  = any && (!msg_valid || msg_ready);
        grant = '0;
        grant[sel] = load;
    end

    // Output register: load on a free slot, drop after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_addr  <= '0;
            msg_data  <= '0;
        end else if (load) begin
            msg_valid <= 1'b1;
            msg_addr  <= ent_addr[sel*64 +: 64];
            msg_data  <= ent_data[sel*32 +: 32];
        end else if (msg_ready) begin
            msg_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/msix_unit.sv
// Top of the interrupt-message vector controller. Holds the enable and
// mask-all bits, forms the effective per-vector mask, decodes the register
// port into table and pending spaces and wires the submodules together.
// Assumes 32-bit word accesses; reg_addr is a word address.
module msix_unit
    import msix_pkg::*;
#(
    parameter int NUM_VEC     = 8,
    parameter int CNT_W       = 4,
    parameter int REG_AW      = 13,
    localparam int VEC_W      = vec_width(NUM_VEC),
    localparam int REQ_W      = VEC_W + 1,
    localparam int PEND_WORDS = ((NUM_VEC + 63) / 64) * 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic              reg_space,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              ctl_wen,
    input  logic              ctl_enable,
    input  logic              ctl_maskall,
    output logic              intx_deassert,
    output logic [10:0]       tbl_size,
    input  logic              req_valid,
    input  logic [REQ_W-1:0]  req_vec,
    input  logic              use_en,
    input  logic              unuse_en,
    input  logic [REQ_W-1:0]  cnt_vec,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [63:0]       msg_addr,
    output logic [31:0]       msg_data
);

    logic                    en_q, maskall_q, fmask;
    logic [NUM_VEC-1:0]      vmask, eff_mask, pend_vec, send_vec, grant_vec;
    logic [NUM_VEC*64-1:0]   ent_addr;
    logic [NUM_VEC*32-1:0]   ent_data;
    logic [31:0]             tbl_rdata, pend_rdata;
    logic [PEND_WORDS*32-1:0] pend_pad;

    assign tbl_size = 11'(NUM_VEC - 1);

    // Capability control bits and the wire-interrupt release pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q          <= 1'b0;
            maskall_q     <= 1'b0;
            intx_deassert <= 1'b0;
        end else begin
            intx_deassert <= ctl_wen && ctl_enable;
            if (ctl_wen) begin
                en_q      <= ctl_enable;
                maskall_q <= ctl_maskall;
            end
        end
    end

    // Effective mask: function-level mask folded into every vector.
    assign fmask    = !en_q || maskall_q;
    assign eff_mask = {NUM_VEC{fmask}} | vmask;

    msix_vec_table #(.NUM_VEC(NUM_VEC), .REG_AW(REG_AW)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wen && !reg_space),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (tbl_rdata),
        .vmask    (vmask),
        .ent_addr (ent_addr),
        .ent_data (ent_data)
    );

    msix_pend_ctl #(.NUM_VEC(NUM_VEC), .REQ_W(REQ_W), .CNT_W(CNT_W)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_vec   (req_vec),
        .use_en    (use_en),
        .unuse_en  (unuse_en),
        .cnt_vec   (cnt_vec),
        .eff_mask  (eff_mask),
        .grant     (grant_vec),
        .pend_q    (pend_vec),
        .send_q    (send_vec)
    );

    msix_msg_out #(.NUM_VEC(NUM_VEC)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .send      (send_vec),
        .ent_addr  (ent_addr),
        .ent_data  (ent_data),
        .msg_ready (msg_ready),
        .grant     (grant_vec),
        .msg_valid (msg_valid),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data)
    );

    // Pending-space read: padded array, zero past the implemented words.
    always_comb begin
        pend_pad = '0;
        pend_pad[NUM_VEC-1:0] = pend_vec;
        pend_rdata = '0;
        if (32'(reg_addr) < PEND_WORDS) pend_rdata = pend_pad[reg_addr*32 +: 32];
    end

    assign reg_rdata = reg_space ? pend_rdata : tbl_rdata;

endmodule

// File: rtl/msix_unit_checker.sv
// Property checker for msix_unit, attached through bind below.
// Observes ports plus the pending and grant vectors between submodules.
module msix_unit_checker #(
    parameter int NUM_VEC = 8,
    parameter int REQ_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [REQ_W-1:0]   req_vec,
    input logic               unuse_en,
    input logic               ctl_wen,
    input logic               ctl_enable,
    input logic               intx_deassert,
    input logic               msg_valid,
    input logic               msg_ready,
    input logic [63:0]        msg_addr,
    input logic [31:0]        msg_data,
    input logic [NUM_VEC-1:0] pending,
    input logic [NUM_VEC-1:0] grant
);

    // R11: a stalled message keeps its contents.
    a_r11_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

    // R11: at most one vector is granted per cycle.
    a_r11_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R5: pending bits only appear after an in-range request.
    a_r5_pend_source: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pending) > $past($countones(pending)) |->
            $past(req_valid && (32'(req_vec) < NUM_VEC)));

    // R8: an out-of-range request never adds a pending bit.
    a_r8_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (32'(req_vec) >= NUM_VEC) && !unuse_en |=>
            $countones(pending) <= $past($countones(pending)));

    // R10: an enabling control write releases the wire interrupt next cycle.
    a_r10_intx_release: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wen && ctl_enable |=> intx_deassert);

endmodule

bind msix_unit msix_unit_checker #(.NUM_VEC(NUM_VEC), .REQ_W(REQ_W)) u_msix_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_vec       (req_vec),
    .unuse_en      (unuse_en),
    .ctl_wen       (ctl_wen),
    .ctl_enable    (ctl_enable),
    .intx_deassert (intx_deassert),
    .msg_valid     (msg_valid),
    .msg_ready     (msg_ready),
    .msg_addr      (msg_addr),
    .msg_data      (msg_data),
    .pending       (pend_vec),
    .grant         (grant_vec)
);

// File: tb/msix_unit_bench.sv
// Self-checking bench: eight vectors, swept through every path.
module msix_unit_bench;
    localparam int NV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0, reg_space = 1'b0;
    logic [12:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        ctl_wen = 1'b0, ctl_enable = 1'b0, ctl_maskall = 1'b0;
    logic        intx_deassert;
    logic [10:0] tbl_size;
    logic        req_valid = 1'b0;
    logic [3:0]  req_vec = '0;
    logic        use_en = 1'b0, unuse_en = 1'b0;
    logic [3:0]  cnt_vec = '0;
    logic        msg_valid, msg_ready = 1'b1;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;
    int checks = 0, errors = 0;
    logic [31:0] d;

    always #2 clk = ~clk;

    msix_unit #(.NUM_VEC(NV), .CNT_W(4), .REG_AW(13)) u_msix_unit (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_space(reg_space),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ctl_wen(ctl_wen), .ctl_enable(ctl_enable), .ctl_maskall(ctl_maskall),
        .intx_deassert(intx_deassert), .tbl_size(tbl_size),
        .req_valid(req_valid), .req_vec(req_vec), .use_en(use_en),
        .unuse_en(unuse_en), .cnt_vec(cnt_vec), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
    );

    function automatic logic [31:0] e_lo(int v);   return 32'hA000_0000 | 32'(v << 4); endfunction
    function automatic logic [31:0] e_hi(int v);   return 32'h0000_1000 + 32'(v);      endfunction
    function automatic logic [31:0] e_data(int v); return 32'hD00D_0000 + 32'(v);      endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick; @(posedge clk); #1; endtask

    task automatic wr(logic sp, int a, logic [31:0] v);
        reg_space = sp; reg_addr = 13'(a); reg_wdata = v; reg_wen = 1'b1;
        tick; reg_wen = 1'b0;
    endtask

    task automatic rd(logic sp, int a, output logic [31:0] r);
        reg_space = sp; reg_addr = 13'(a); #1; r = reg_rdata;
    endtask

    task automatic ctl(logic en, logic ma);
        ctl_enable = en; ctl_maskall = ma; ctl_wen = 1'b1;
        tick; ctl_wen = 1'b0;
    endtask

    task automatic use_v(int v);   cnt_vec = 4'(v); use_en = 1'b1;   tick; use_en = 1'b0;   endtask
    task automatic unuse_v(int v); cnt_vec = 4'(v); unuse_en = 1'b1; tick; unuse_en = 1'b0; endtask
    task automatic req_v(int v);   req_vec = 4'(v); req_valid = 1'b1; tick; req_valid = 1'b0; endtask

    task automatic chk_msg(string tag, int v);
        chk(tag, 64'(msg_valid), 64'd1);
        chk(tag, msg_addr, {e_hi(v), e_lo(v)});
        chk(tag, 64'(msg_data), 64'(e_data(v)));
    endtask

    task automatic chk_idle(string tag); chk(tag, 64'(msg_valid), 64'd0); endtask

    task automatic chk_reset_state(string tag);
        for (int v = 0; v < NV + 1; v++) begin
            for (int k = 0; k < 4; k++) begin
                rd(1'b0, v*4 + k, d);
                chk(tag, 64'(d), (k == 3 && v < NV) ? 64'd1 : 64'd0);
            end
        end
        for (int w = 0; w < 3; w++) begin rd(1'b1, w, d); chk(tag, 64'(d), 64'd0); end
        chk(tag, 64'(msg_valid), 64'd0);
        chk(tag, 64'(intx_deassert), 64'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick; tick; rst_n = 1'b1; tick;
        // R3 reset state, R1 size report
        chk_reset_state("R3 reset");
        chk("R1 size", 64'(tbl_size), 64'(NV - 1));

        // R2 program and read back every entry; control word keeps bit 0 only
        for (int v = 0; v < NV; v++) begin
            wr(1'b0, v*4 + 0, e_lo(v));
            wr(1'b0, v*4 + 1, e_hi(v));
            wr(1'b0, v*4 + 2, e_data(v));
            wr(1'b0, v*4 + 3, 32'hFFFF_FFFF);
        end
        for (int v = 0; v < NV; v++) begin
            rd(1'b0, v*4 + 0, d); chk("R2 addr lo", 64'(d), 64'(e_lo(v)));
            rd(1'b0, v*4 + 1, d); chk("R2 addr hi", 64'(d), 64'(e_hi(v)));
            rd(1'b0, v*4 + 2, d); chk("R2 data", 64'(d), 64'(e_data(v)));
            rd(1'b0, v*4 + 3, d); chk("R2 ctrl", 64'(d), 64'd1);
        end
        wr(1'b0, NV*4, 32'h1234_5678);
        rd(1'b0, NV*4, d); chk("R2 beyond", 64'(d), 64'd0);
        rd(1'b0, 0, d);    chk("R2 no alias", 64'(d), 64'(e_lo(0)));

        // R8 zero use count: request ignored even though nothing is enabled
        req_v(2);
        rd(1'b1, 0, d); chk("R8 count zero", 64'(d), 64'd0);

        // R5 use all vectors, enable, park a request on each masked vector
        for (int v = 0; v < NV; v++) use_v(v);
        ctl(1'b1, 1'b0);
        chk("R10 enable pulse", 64'(intx_deassert), 64'd1);
        tick;
        chk("R10 pulse width", 64'(intx_deassert), 64'd0);
        for (int v = 0; v < NV; v++) begin
            req_v(v);
            rd(1'b1, 0, d); chk("R5 park", 64'(d), 64'((1 << (v + 1)) - 1));
            chk_idle("R5 no message");
        end
        tick; chk_idle("R5 no message late");
        rd(1'b1, 1, d); chk("R6 upper word", 64'(d), 64'd0);

        // R7 unmask vector 3 through its table entry
        wr(1'b0, 3*4 + 3, 32'd0);
        chk_idle("R7 table unmask E");
        tick; chk_idle("R7 table unmask E+1");
        tick; chk_msg("R7 table replay", 3);
        tick; chk_idle("R7 after replay");
        rd(1'b1, 0, d); chk("R7 pending cleared", 64'(d), 64'h0F7);

        // R7/R11 mask-all held while vector masks drop, then burst replay
        ctl(1'b1, 1'b1);
        for (int v = 0; v < NV; v++) if (v != 3) wr(1'b0, v*4 + 3, 32'd0);
        tick; chk_idle("R7 mask-all holds");
        ctl(1'b1, 1'b0);
        tick; chk_idle("R7 burst E+1");
        for (int v = 0; v < NV; v++) begin
            if (v != 3) begin
                tick; chk_msg("R11 ascending burst", v);
            end
        end
        tick; chk_idle("R11 burst end");
        rd(1'b1, 0, d); chk("R7 burst cleared", 64'(d), 64'd0);

        // R4 direct delivery on every unmasked vector
        for (int v = 0; v < NV; v++) begin
            req_v(v);
            chk_idle("R4 not before E+1");
            tick; chk_msg("R4 delivery", v);
            tick; chk_idle("R4 consumed");
        end

        // R8 out-of-range vector numbers
        req_v(NV);
        tick; chk_idle("R8 range low");
        req_v(15);
        tick; chk_idle("R8 range high");
        rd(1'b1, 0, d); chk("R8 no pending", 64'(d), 64'd0);

        // R11 stall: contents held, then ascending drain
        msg_ready = 1'b0;
        req_vec = 4'd6; req_valid = 1'b1; tick;
        req_vec = 4'd2; tick;
        chk_msg("R11 stall first", 6);
        req_vec = 4'd4; tick; req_valid = 1'b0;
        chk_msg("R11 stall hold", 6);
        tick; chk_msg("R11 stall hold 2", 6);
        msg_ready = 1'b1;
        tick; chk_msg("R11 drain low", 2);
        tick; chk_msg("R11 drain next", 4);
        tick; chk_idle("R11 drain end");

        // R9 use counting on vector 1
        use_v(1);
        wr(1'b0, 1*4 + 3, 32'd1);
        req_v(1);
        rd(1'b1, 0, d); chk("R9 parked", 64'(d), 64'h02);
        unuse_v(1);
        rd(1'b1, 0, d); chk("R9 count two to one keeps", 64'(d), 64'h02);
        unuse_v(1);
        rd(1'b1, 0, d); chk("R9 zero clears pending", 64'(d), 64'd0);
        unuse_v(1);
        req_v(1);
        rd(1'b1, 0, d); chk("R8 R9 zero count ignored", 64'(d), 64'd0);
        use_v(1);
        req_v(1);
        rd(1'b1, 0, d); chk("R9 unuse at zero no effect", 64'(d), 64'h02);
        wr(1'b0, 1*4 + 3, 32'd0);
        tick; tick; chk_msg("R7 vector 1 replay", 1);
        tick; chk_idle("R7 vector 1 done");

        // R6 pending space is read-only
        wr(1'b1, 0, 32'hFFFF_FFFF);
        rd(1'b1, 0, d); chk("R6 write ignored", 64'(d), 64'd0);

        // R10/R4 disable: no pulse, requests park; re-enable replays
        ctl(1'b0, 1'b0);
        chk("R10 disable no pulse", 64'(intx_deassert), 64'd0);
        req_v(0);
        tick; chk_idle("R4 disabled masks");
        rd(1'b1, 0, d); chk("R5 disabled parks", 64'(d), 64'h01);
        ctl(1'b1, 1'b0);
        chk("R10 re-enable pulse", 64'(intx_deassert), 64'd1);
        tick; chk_idle("R7 enable E+1");
        tick; chk_msg("R7 enable replay", 0);
        tick; chk_idle("R7 enable done");

        // R3 reset again after activity; use counts return to zero
        req_vec = 4'd5; req_valid = 1'b1; rst_n = 1'b0;
        tick; tick; req_valid = 1'b0; rst_n = 1'b1; tick;
        chk_reset_state("R3 second reset");
        ctl(1'b1, 1'b0);
        for (int v = 0; v < NV; v++) wr(1'b0, v*4 + 3, 32'd0);
        req_v(4);
        tick; chk_idle("R3 counts cleared");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule